// File: doc/BRIEF.md
# Operand-Inverting Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit for 29-bit words. Either operand can be bitwise inverted on its way in. A 4-bit operation code then selects among addition, addition with a stored carry, three bitwise operations, a pass-through of operand A, and shifts of A by the amount held in B. Besides the result, the unit reports a carry-out, a signed overflow and an equality indication of the two conditioned operands, so that a sequencer can use the same path for compare instructions.

The only state is a one-bit carry flag. It is written from the adder carry-out when an addition is committed, and it supplies the carry-in of the add-with-carry operation. Every result word leaves the block with bit 29 forced high, so the 30-bit output word never has a zero upper bit.

Top module: `operand_invert_alu`

## Requirements
- R1: With op_i = 1 (add), res_o[28:0] is the low 29 bits of A' + B', and carry_o is bit 29 of that sum. A' and B' are the operands after optional inversion.
- R2: With op_i = 2 (add with carry), res_o[28:0] and carry_o come from A' + B' + cflag_o.
- R3: With op_i = 3, 4 and 5, res_o[28:0] is A' AND B', A' OR B' and A' XOR B' respectively.
- R4: With op_i = 6, res_o[28:0] equals A'.
- R5: With op_i = 7, res_o[28:0] is A' shifted right by the unsigned value of B'. With op_i = 8 it is A' shifted left by that value. Vacated bits fill with 0, and an amount of 29 or more gives 0.
- R6: inv_a_i = 1 replaces A by its bitwise complement and inv_b_i = 1 does the same for B. The two controls act independently and may both be set.
- R7: For op_i = 1 and 2, ovf_o = 1 exactly when A' and B' share bit 28 and the sum's bit 28 differs from it. For every other code, carry_o and ovf_o are 0.
- R8: eq_o = 1 exactly when A' equals B', whatever the value of op_i.
- R9: res_o[29] is 1 for every input.
- R10: cflag_o is 0 after reset. At a rising clock edge with commit_i = 1 and op_i of 1 or 2, it takes the carry_o value present before that edge. In all other cases it holds.
- R11: Unused codes (0 and 9 to 15) give res_o[28:0] = 0, and committing them leaves cflag_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the carry flag |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opa_i | input | 29 | Operand A |
| opb_i | input | 29 | Operand B |
| op_i | input | 4 | Operation code |
| inv_a_i | input | 1 | Invert operand A |
| inv_b_i | input | 1 | Invert operand B |
| commit_i | input | 1 | The current result is committed; enables the flag update |
| res_o | output | 30 | Result, with bit 29 forced to 1 |
| carry_o | output | 1 | Adder carry-out |
| ovf_o | output | 1 | Signed overflow of the addition |
| eq_o | output | 1 | Conditioned operands are equal |
| cflag_o | output | 1 | Stored carry flag |

## Verification
The only internal state is the carry flag. A flag loaded on the wrong code, or left unloaded, shows up directly on cflag_o one clock after the commit. It also shows up in the next add-with-carry result, where the sum is off by exactly one. The bench therefore compares cflag_o after every clock and follows committed additions with add-with-carry vectors. Faults in the combinational path appear in the same cycle on res_o, carry_o, ovf_o or eq_o. The sum boundaries, the signed limits and shift amounts around 29 are driven on purpose so that those faults are exposed.

// File: rtl/oia_pkg.sv
package oia_pkg;
   typedef enum logic [3:0] {
      OP_NONE = 4'd0,
      OP_ADD  = 4'd1,
      OP_ADC  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_PASS = 4'd6,
      OP_SHR  = 4'd7,
      OP_SHL  = 4'd8
   } oia_op_e;
endpackage

// File: rtl/oia_cond.sv
module oia_cond #(
   parameter int DATA_W = 29
) (
   input  logic [DATA_W-1:0] din_i,
   input  logic              inv_i,
   output logic [DATA_W-1:0] dout_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign dout_o[i] = din_i[i] ^ inv_i;
   end
endmodule

// File: rtl/oia_adder.sv
module oia_adder #(
   parameter int DATA_W = 29,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              ovf_o
);
   localparam int MSB = DATA_W - 1;

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] cy;
      assign cy[0] = cin_i;
      for (genvar i = 0; i < DATA_W; i++) begin : g_fa
         assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
         assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
      end
      assign cout_o = cy[DATA_W];
   end else begin : g_behav
      logic [DATA_W:0] wide;
      assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
      assign sum_o  = wide[DATA_W-1:0];
      assign cout_o = wide[DATA_W];
   end

   assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/oia_shifter.sv
module oia_shifter #(
   parameter int DATA_W = 29
) (
   input  logic [DATA_W-1:0] din_i,
   input  logic [DATA_W-1:0] amt_i,
   input  logic              left_i,
   output logic [DATA_W-1:0] dout_o
);
   localparam int STAGES = $clog2(DATA_W);

   logic [STAGES:0][DATA_W-1:0] st;
   logic                        too_far;

   assign st[0]   = din_i;
   assign too_far = (amt_i >= DATA_W[DATA_W-1:0]);

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      always_comb begin
         if (!amt_i[k])   st[k+1] = st[k];
         else if (left_i) st[k+1] = st[k] << (1 << k);
         else             st[k+1] = st[k] >> (1 << k);
      end
   end

   assign dout_o = too_far ? '0 : st[STAGES];
endmodule

// File: rtl/oia_flag.sv
module oia_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o <= 1'b0;
      else if (load_i) q_o <= d_i;
   end
endmodule

// File: rtl/operand_invert_alu.sv
module operand_invert_alu #(
   parameter int DATA_W = 29,
   parameter int OP_W   = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic              inv_a_i,
   input  logic              inv_b_i,
   input  logic              commit_i,
   output logic [DATA_W:0]   res_o,
   output logic              carry_o,
   output logic              ovf_o,
   output logic              eq_o,
   output logic              cflag_o
);
   import oia_pkg::*;

   localparam int RES_W = DATA_W + 1;

   if (DATA_W < 8) begin : g_bad_width
      $error("operand_invert_alu: DATA_W must be at least 8");
   end
   if (OP_W != 4) begin : g_bad_op
      $error("operand_invert_alu: OP_W must be 4");
   end

   logic [DATA_W-1:0] a_c, b_c, sum, shifted;
   logic              add_cout, add_ovf, cin, is_arith;
   logic [DATA_W-1:0] core;

   oia_cond #(.DATA_W(DATA_W)) cond_a_i (.din_i(opa_i), .inv_i(inv_a_i), .dout_o(a_c));
   oia_cond #(.DATA_W(DATA_W)) cond_b_i (.din_i(opb_i), .inv_i(inv_b_i), .dout_o(b_c));

   assign cin      = (op_i == OP_ADC) ? cflag_o : 1'b0;
   assign is_arith = (op_i == OP_ADD) || (op_i == OP_ADC);

   oia_adder #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) add_i (
      .a_i(a_c), .b_i(b_c), .cin_i(cin),
      .sum_o(sum), .cout_o(add_cout), .ovf_o(add_ovf)
   );

   oia_shifter #(.DATA_W(DATA_W)) shf_i (
      .din_i(a_c), .amt_i(b_c), .left_i(op_i == OP_SHL), .dout_o(shifted)
   );

   always_comb begin
      case (op_i)
         OP_ADD, OP_ADC: core = sum;
         OP_AND:         core = a_c & b_c;
         OP_OR:          core = a_c | b_c;
         OP_XOR:         core = a_c ^ b_c;
         OP_PASS:        core = a_c;
         OP_SHR, OP_SHL: core = shifted;
         default:        core = '0;
      endcase
   end

   assign res_o   = {1'b1, core} | {1'b1, {(RES_W-1){1'b0}}};
   assign carry_o = is_arith & add_cout;
   assign ovf_o   = is_arith & add_ovf;
   assign eq_o    = (a_c == b_c);

   oia_flag flag_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(commit_i & is_arith), .d_i(add_cout), .q_o(cflag_o)
   );
endmodule

// File: rtl/oia_checker.sv
module oia_checker #(
   parameter int DATA_W = 29
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [DATA_W-1:0] opa_i,
   input logic [DATA_W-1:0] opb_i,
   input logic [3:0]        op_i,
   input logic              inv_a_i,
   input logic              inv_b_i,
   input logic              commit_i,
   input logic [DATA_W:0]   res_o,
   input logic              carry_o,
   input logic              ovf_o,
   input logic              eq_o,
   input logic              cflag_o
);
   AST_TOP_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_o[DATA_W] == 1'b1); // R9

   AST_FLAG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_i && (op_i == 4'd1 || op_i == 4'd2) |=> cflag_o == $past(carry_o)); // R10

   AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(commit_i && (op_i == 4'd1 || op_i == 4'd2)) |=> $stable(cflag_o)); // R10

   AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 4'd0 || op_i > 4'd8) |-> res_o[DATA_W-1:0] == '0 && !carry_o && !ovf_o); // R11

   AST_PASS_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == 4'd6 && !inv_a_i |-> res_o[DATA_W-1:0] == opa_i); // R4

   AST_XOR_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == 4'd5 |-> eq_o == (res_o[DATA_W-1:0] == '0)); // R8

   AST_LOGIC_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i >= 4'd3 |-> !carry_o && !ovf_o); // R7
endmodule

bind operand_invert_alu oia_checker #(.DATA_W(DATA_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i),
   .inv_a_i(inv_a_i), .inv_b_i(inv_b_i), .commit_i(commit_i), .res_o(res_o),
   .carry_o(carry_o), .ovf_o(ovf_o), .eq_o(eq_o), .cflag_o(cflag_o)
);

// File: tb/operand_invert_alu_tb_top.sv
`timescale 1ns/1ps
module operand_invert_alu_tb_top;
   localparam int W = 29;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  opa = '0, opb = '0;
   logic [3:0]    op = '0;
   logic          inv_a = 1'b0, inv_b = 1'b0, commit = 1'b0;
   logic [W:0]    res;
   logic          carry, ovf, eq, cflag;

   int checks = 0, fails = 0;
   logic model_flag = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   operand_invert_alu dut_i (
      .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb), .op_i(op),
      .inv_a_i(inv_a), .inv_b_i(inv_b), .commit_i(commit),
      .res_o(res), .carry_o(carry), .ovf_o(ovf), .eq_o(eq), .cflag_o(cflag)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // returns {eq, ovf, carry, result[28:0]}
   function automatic logic [31:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [3:0] o, input logic ia, input logic ib,
                                         input logic fl);
      logic [W-1:0] ac, bc, r;
      logic [W:0]   s;
      logic         c, v;
      ac = ia ? ~a : a;
      bc = ib ? ~b : b;
      s  = {1'b0, ac} + {1'b0, bc} + {{W{1'b0}}, (o == 4'd2) ? fl : 1'b0};
      c = 1'b0; v = 1'b0;
      case (o)
         4'd1, 4'd2: begin
            r = s[W-1:0];
            c = s[W];
            v = (ac[W-1] == bc[W-1]) && (s[W-1] != ac[W-1]);
         end
         4'd3: r = ac & bc;
         4'd4: r = ac | bc;
         4'd5: r = ac ^ bc;
         4'd6: r = ac;
         4'd7: r = (bc >= W) ? '0 : ac >> bc;
         4'd8: r = (bc >= W) ? '0 : ac << bc;
         default: r = '0;
      endcase
      return {ac == bc, v, c, r};
   endfunction

   function automatic string tag(input logic [3:0] o, input logic ia, input logic ib);
      if (ia || ib) return "R6";
      case (o)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3, 4'd4, 4'd5: return "R3";
         4'd6: return "R4";
         4'd7, 4'd8: return "R5";
         default: return "R11";
      endcase
   endfunction

   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] o,
                      input logic ia, input logic ib, input logic cm);
      logic [31:0] e;
      @(negedge clk);
      opa = a; opb = b; op = o; inv_a = ia; inv_b = ib; commit = cm;
      #1;
      e = model(a, b, o, ia, ib, model_flag);
      chk(tag(o, ia, ib), "result", {3'b0, res[W-1:0]}, {3'b0, e[W-1:0]});
      chk("R9", "top bit", {31'b0, res[W]}, 32'd1);
      chk("R7", "carry", {31'b0, carry}, {31'b0, e[29]});
      chk("R7", "overflow", {31'b0, ovf}, {31'b0, e[30]});
      chk("R8", "equal", {31'b0, eq}, {31'b0, e[31]});
      @(posedge clk);
      #1;
      if (cm && (o == 4'd1 || o == 4'd2)) model_flag = e[29];
      chk((o == 4'd0 || o > 4'd8) ? "R11" : "R10", "carry flag", {31'b0, cflag}, {31'b0, model_flag});
   endtask

   localparam logic [W-1:0] ALL1 = {W{1'b1}};
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      repeat (3) @(posedge clk);
      #1 chk("R10", "flag in reset", {31'b0, cflag}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      #1 chk("R10", "flag after reset", {31'b0, cflag}, 32'd0);

      // R1 carry out and flag load, then R2 uses it
      run(ALL1, 29'd1, 4'd1, 0, 0, 1);
      run(29'd5, 29'd7, 4'd2, 0, 0, 0);
      // R11 unused code committed keeps flag
      run(29'd3, 29'd4, 4'd0, 0, 0, 1);
      run(29'd3, 29'd4, 4'd13, 0, 0, 1);
      run(ALL1, ALL1, 4'd2, 0, 0, 1);
      // R10 non-add commit holds
      run(29'd0, 29'd0, 4'd3, 0, 0, 1);
      run(29'd1, 29'd1, 4'd2, 0, 0, 1);
      // R7 signed overflow limits
      run(SMAX, 29'd1, 4'd1, 0, 0, 0);
      run(~SMAX, ALL1, 4'd1, 0, 0, 0);
      // R5 shift boundaries
      run(ALL1, 29'd28, 4'd7, 0, 0, 0);
      run(ALL1, 29'd28, 4'd8, 0, 0, 0);
      run(ALL1, 29'd29, 4'd7, 0, 0, 0);
      run(ALL1, 29'd29, 4'd8, 0, 0, 0);
      run(29'h1234567, 29'd0, 4'd8, 0, 0, 0);
      // R6 inversion, both together; R8 equality through inversion
      run(29'h0F0F0F0, 29'h0, 4'd6, 1, 0, 0);
      run(29'h00000AA, 29'h1FFFF55, 4'd5, 0, 1, 0);
      run(29'h0, 29'h0, 4'd1, 1, 1, 1);
      run(29'd2, ~29'd27, 4'd7, 0, 1, 0);

      for (int i = 0; i < 3000; i++) begin
         logic [3:0]   o;
         logic [W-1:0] b;
         o = 4'($urandom_range(0, 15));
         b = W'($urandom);
         if ((o == 4'd7 || o == 4'd8) && i[0]) b = W'($urandom_range(0, 34));
         if (i % 17 == 0) b = W'($urandom);
         run(W'($urandom), (i % 23 == 0) ? opa : b, o, 1'($urandom), 1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule